// File: doc/BRIEF.md
# Change-of-State Digital Input Interrupt Controller

This block is a byte-addressed digital I/O port. It has 24 latched output lines, 24 input lines and 8 lines that can be switched between driving and sensing. The block watches every input line and the 8 switchable lines for transitions. A transition in a direction the host has enabled for that line's group of eight is recorded in a sticky status bit. One level interrupt stays high while any status bit is set.

The host talks to the block over a small bus with a 4-bit address, a read strobe, a write strobe and 8-bit write and read data. It enables the rising and falling detection for each group of eight. When the interrupt arrives, it reads the status bytes to find which lines changed. It then writes those same bytes back to the same offsets, which clears exactly the bits that were reported. Each external input passes through a two-flop synchronizer before it is read or compared.

Top module: `cos_dio_ctrl`

## Requirements
- R1: After reset, all output latches are 0, the switchable lines are not driven (`dir_oe` = 0), the enable register is 0, every status bit is 0 and `irq` is 0.
- R2: Offsets 0x0, 0x1 and 0x2 are read/write latches for output lines 7:0, 15:8 and 23:16, and offset 0x3 is the read/write latch for `sw_out`. A write shows on the output pins after the clock edge that samples it.
- R3: Offsets 0x4, 0x5 and 0x6 read input lines 7:0, 15:8 and 23:16, and offset 0x7 reads the switchable lines. All of these are taken after a two-flop synchronizer.
- R4: Offset 0xE is a read/write enable register. For group g (0, 1, 2 = input bytes, 3 = switchable lines), bit g enables rising-edge detection and bit g+4 enables falling-edge detection.
- R5: A status bit is set only for a transition whose direction is enabled for its group. Groups with no enabled direction, and directions that are not enabled, never set status.
- R6: Reading offsets 0x8 to 0xA returns the status of input bytes 0 to 2, and reading 0xB returns the status of the switchable lines. Writing one of these offsets clears only the status bits written as 1.
- R7: `irq` is high exactly while at least one status bit is set. It stays high after the enables are cleared, until every set bit has been cleared.
- R8: If a qualifying edge for a bit and a clear write of that same bit are sampled on the same clock edge, the bit stays set.
- R9: Bit 0 of offset 0xC drives `dir_oe`, which selects whether the switchable lines are driven from their latch (1) or used as inputs (0). The bit reads back at offset 0xC.
- R10: `bus_rdata` is loaded on the clock edge after a sampled read strobe and holds its value until the next read. Reading an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| in_lines | input | 24 | Asynchronous input lines |
| sw_in | input | 8 | Sensed level of the switchable lines |
| out_lines | output | 24 | Latched output lines |
| sw_out | output | 8 | Latch value for the switchable lines |
| dir_oe | output | 1 | Drive enable for the switchable lines |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The checker covers the rules that hold on every cycle:
- The interrupt can only rise when an enable was set on the cycle before.
- The interrupt can only fall after a write.
- Without a write, the interrupt stays high and the output latches and drive enable hold steady.
- A group with both directions disabled never gains a status bit.

Only the bench's scenarios can show the following, because each needs chosen input patterns and exact timing:
- Which bits a given edge pattern sets.
- The mask behaviour of clear writes.
- The synchronizer latency.
- The same-cycle edge-versus-clear case.

// File: rtl/cos_dio_pkg.sv
package cos_dio_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int ISO_BYTES = 3;
    localparam int GROUPS    = ISO_BYTES + 1;
    localparam int ISO_W     = ISO_BYTES * BYTE_W;
    localparam int LINE_W    = GROUPS * BYTE_W;
    localparam int EN_W      = 2 * GROUPS;

    // Offsets: each group g sits at base + g in the latch, pin and status windows.
    localparam int OFS_LATCH  = 0;
    localparam int OFS_PIN    = 4;
    localparam int OFS_STATUS = 8;
    localparam int OFS_DIR    = 12;
    localparam int OFS_EN     = 14;
endpackage

// File: rtl/cos_dio_sync.sv
module cos_dio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] last;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = din;
        st_d.stable = st_q.meta;
        st_d.last   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.stable;
    assign prev = st_q.last;
endmodule

// File: rtl/cos_dio_detect.sv
module cos_dio_detect #(
    parameter int GW = 8,
    parameter int NG = 4,
    localparam int LW = GW * NG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cur,
    input  logic [LW-1:0] prev,
    input  logic [NG-1:0] rise_en,
    input  logic [NG-1:0] fall_en,
    input  logic [LW-1:0] clr_mask,
    output logic [LW-1:0] status,
    output logic          irq
);
    typedef struct packed {
        logic [LW-1:0] flags;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [LW-1:0] rise_mask, fall_mask, hits;

    // Widen each group enable bit across the eight lines of its group.
    for (genvar g = 0; g < NG; g++) begin : g_mask
        assign rise_mask[g*GW +: GW] = {GW{rise_en[g]}};
        assign fall_mask[g*GW +: GW] = {GW{fall_en[g]}};
    end

    always_comb begin
        hits = (cur & ~prev & rise_mask) | (~cur & prev & fall_mask);
        st_d = st_q;
        // A new hit wins over a clear on the same edge.
        st_d.flags = (st_q.flags & ~clr_mask) | hits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.flags;
    assign irq    = |st_q.flags;
endmodule

// File: rtl/cos_dio_regs.sv
module cos_dio_regs
    import cos_dio_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NG = GROUPS,
    parameter int AW = ADDR_W,
    localparam int LW = BW * NG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [BW-1:0] wdata,
    input  logic [LW-1:0] pins,
    input  logic [LW-1:0] status,
    output logic [LW-1:0] clr_mask,
    output logic [LW-1:0] latch,
    output logic [BW-1:0] en,
    output logic          dir,
    output logic [BW-1:0] rdata
);
    typedef struct packed {
        logic [LW-1:0] latch;
        logic [BW-1:0] en;
        logic          dir;
        logic [BW-1:0] rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [BW-1:0] rd_val;
    logic [LW-1:0] clr_d;
    int            ofs;

    always_comb begin
        st_d   = st_q;
        rd_val = '0;
        clr_d  = '0;
        ofs    = int'(addr);
        for (int g = 0; g < NG; g++) begin
            if (ofs == OFS_LATCH + g) begin
                rd_val = st_q.latch[g*BW +: BW];
                if (wr) st_d.latch[g*BW +: BW] = wdata;
            end
            if (ofs == OFS_PIN + g) begin
                rd_val = pins[g*BW +: BW];
            end
            if (ofs == OFS_STATUS + g) begin
                rd_val = status[g*BW +: BW];
                if (wr) clr_d[g*BW +: BW] = wdata;
            end
        end
        if (ofs == OFS_DIR) begin
            rd_val = {{(BW-1){1'b0}}, st_q.dir};
            if (wr) st_d.dir = wdata[0];
        end
        if (ofs == OFS_EN) begin
            rd_val = st_q.en;
            if (wr) st_d.en = wdata;
        end
        if (rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clr_mask = clr_d;
    assign latch    = st_q.latch;
    assign en       = st_q.en;
    assign dir      = st_q.dir;
    assign rdata    = st_q.rdata;
endmodule

// File: rtl/cos_dio_ctrl.sv
module cos_dio_ctrl
    import cos_dio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [ISO_W-1:0]  in_lines,
    input  logic [BYTE_W-1:0] sw_in,
    output logic [ISO_W-1:0]  out_lines,
    output logic [BYTE_W-1:0] sw_out,
    output logic              dir_oe,
    output logic              irq
);
    logic [LINE_W-1:0] raw_vec, cur_vec, prev_vec;
    logic [LINE_W-1:0] status_vec, clr_vec, latch_vec;
    logic [BYTE_W-1:0] en_vec;
    logic [GROUPS-1:0] rise_en, fall_en;

    assign raw_vec = {sw_in, in_lines};
    assign rise_en = en_vec[GROUPS-1:0];
    assign fall_en = en_vec[EN_W-1:GROUPS];

    cos_dio_sync #(.W(LINE_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_vec),
        .cur  (cur_vec),
        .prev (prev_vec)
    );

    cos_dio_regs #(.BW(BYTE_W), .NG(GROUPS), .AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .pins    (cur_vec),
        .status  (status_vec),
        .clr_mask(clr_vec),
        .latch   (latch_vec),
        .en      (en_vec),
        .dir     (dir_oe),
        .rdata   (bus_rdata)
    );

    cos_dio_detect #(.GW(BYTE_W), .NG(GROUPS)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (cur_vec),
        .prev    (prev_vec),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .clr_mask(clr_vec),
        .status  (status_vec),
        .irq     (irq)
    );

    assign out_lines = latch_vec[ISO_W-1:0];
    assign sw_out    = latch_vec[LINE_W-1:ISO_W];
endmodule

// File: rtl/cos_dio_chk.sv
module cos_dio_chk #(
    parameter int BW = 8,
    parameter int NG = 4,
    parameter int OW = 24,
    localparam int LW = BW * NG
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [OW-1:0] out_lines,
    input logic          dir_oe,
    input logic          irq,
    input logic [BW-1:0] en,
    input logic [LW-1:0] status
);
    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|en));

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq);

    assert_irq_fall_after_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr));

    assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(out_lines));

    assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(dir_oe));

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assert_quiet_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[g] && !en[g+NG]) |=>
            ((status[g*BW +: BW] & ~$past(status[g*BW +: BW])) == '0));
    end
endmodule

bind cos_dio_ctrl cos_dio_chk #(.BW(8), .NG(4), .OW(24)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .out_lines(out_lines),
    .dir_oe   (dir_oe),
    .irq      (irq),
    .en       (en_vec),
    .status   (status_vec)
);

// File: tb/sim_cos_dio_ctrl.sv
module sim_cos_dio_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] in_lines = '0;
    logic [7:0]  sw_in = '0;
    logic [23:0] out_lines;
    logic [7:0]  sw_out;
    logic        dir_oe;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic rd_d = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cos_dio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_lines(in_lines), .sw_in(sw_in), .out_lines(out_lines),
        .sw_out(sw_out), .dir_oe(dir_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: a read sampled at a posedge has data ready by the next negedge.
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
            else check(tag_q.pop_front(), {24'd0, bus_rdata}, {24'd0, exp_q.pop_front()});
        end
    end

    task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check("R1 out_lines", {8'd0, out_lines}, 32'd0);
        check("R1 sw_out", {24'd0, sw_out}, 32'd0);
        check("R1 dir_oe", {31'd0, dir_oe}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        bus_read(4'hE, 8'h00, "R1 enable reg");
        bus_read(4'h8, 8'h00, "R1 status byte0");

        // R2: output latches
        bus_write(4'h0, 8'hA5);
        bus_write(4'h1, 8'h3C);
        bus_write(4'h2, 8'hF0);
        bus_write(4'h3, 8'h81);
        check("R2 out_lines", {8'd0, out_lines}, 32'h00F03CA5);
        check("R2 sw_out", {24'd0, sw_out}, 32'h81);
        bus_read(4'h1, 8'h3C, "R2 readback byte1");
        bus_read(4'h3, 8'h81, "R2 readback sw latch");

        // R9: direction
        bus_write(4'hC, 8'h01);
        check("R9 dir_oe set", {31'd0, dir_oe}, 32'd1);
        bus_read(4'hC, 8'h01, "R9 readback");
        bus_write(4'hC, 8'h00);
        check("R9 dir_oe clear", {31'd0, dir_oe}, 32'd0);

        // R3: synchronized pin reads; R5: disabled groups record nothing
        @(negedge clk);
        in_lines = 24'h123456;
        sw_in    = 8'h9A;
        idle(3);
        bus_read(4'h4, 8'h56, "R3 in byte0");
        bus_read(4'h5, 8'h34, "R3 in byte1");
        bus_read(4'h6, 8'h12, "R3 in byte2");
        bus_read(4'h7, 8'h9A, "R3 sw pins");
        check("R5 no irq while disabled", {31'd0, irq}, 32'd0);
        bus_read(4'h8, 8'h00, "R5 no status while disabled");

        // R4/R5: rising only on group 0
        bus_write(4'hE, 8'h01);
        bus_read(4'hE, 8'h01, "R4 enable readback");
        @(negedge clk);
        in_lines = 24'h1200FF;   // byte0 56->FF rises 0xA9, byte1 falls (disabled)
        idle(4);
        check("R7 irq after edge", {31'd0, irq}, 32'd1);
        bus_read(4'h8, 8'hA9, "R5 rising bits byte0");
        bus_read(4'h9, 8'h00, "R5 disabled group1");
        @(negedge clk);
        in_lines = 24'h12000F;   // falling in group 0, not enabled
        idle(4);
        bus_read(4'h8, 8'hA9, "R5 falling ignored");

        // R6: masked clear; R7: irq survives disabling
        bus_write(4'h8, 8'h09);
        bus_read(4'h8, 8'hA0, "R6 partial clear");
        bus_write(4'hE, 8'h00);
        check("R7 irq held after disable", {31'd0, irq}, 32'd1);
        bus_write(4'h8, 8'hA0);
        check("R7 irq low after clear", {31'd0, irq}, 32'd0);
        bus_read(4'h8, 8'h00, "R6 full clear");

        // R4/R6: falling on switchable group via bit 7, status at 0xB
        bus_write(4'hE, 8'h80);
        @(negedge clk);
        sw_in = 8'h18;           // 9A->18 falls bits 7,1
        idle(4);
        bus_read(4'hB, 8'h82, "R6 sw status");
        bus_read(4'h8, 8'h00, "R6 byte0 untouched");
        check("R7 irq from sw group", {31'd0, irq}, 32'd1);
        bus_write(4'hB, 8'h82);
        check("R6 irq after sw clear", {31'd0, irq}, 32'd0);

        // R8: edge and clear on the same edge
        bus_write(4'hE, 8'h11);
        @(negedge clk);
        in_lines = 24'h12001F;   // rise bit4
        idle(4);
        bus_read(4'h8, 8'h10, "R8 setup");
        @(negedge clk);
        in_lines = 24'h12001E;   // fall bit0, hit lands two edges later
        @(negedge clk);
        bus_write(4'h8, 8'h11);  // sampled on the same edge as the hit
        bus_read(4'h8, 8'h01, "R8 edge beats clear");
        bus_write(4'h8, 8'h01);
        bus_read(4'h8, 8'h00, "R8 plain clear");

        // R10: read data holding and unmapped offsets
        bus_read(4'h0, 8'hA5, "R10 read byte0");
        bus_write(4'h0, 8'h11);
        check("R10 rdata held", {24'd0, bus_rdata}, 32'hA5);
        bus_read(4'hD, 8'h00, "R10 unmapped");

        idle(3);
        check("scoreboard drained", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule